// File: doc/BRIEF.md
# Flash Block Write-Lock Bank

This block holds one small lock register per erase block of a flash array and decides, block by block, whether program and erase are allowed. Each register carries a write-lock flag and a sticky lock-down flag. Software reads and writes the registers through a simple port that selects a register by its block index. Two active-low hardware protect pins also feed the decision. One pin guards the topmost (boot) block. The other pin guards every other block. The pin levels never show up in the value read back from a register.

The block drives a live per-block permit vector. It also has a sampling port for the program/erase controller. When the controller starts an operation on a block, the bank captures the permission for that block in that cycle and presents it on the following cycle. The decision stays fixed for the whole operation, whatever happens to the registers or pins afterwards. While the controller reports an internal write in progress, register accesses are dropped.

Top module: `blk_lock_bank`

## Requirements
- R1: Register layout: bit 0 is write-lock and bit 1 is lock-down. Bits 7..2 always read 0, and the values written to them are discarded.
- R2: After reset every register reads 8'h01, reg_rvalid is 0, reg_rdata is 8'h00 and op_grant_valid is 0.
- R3: With both pins high, wr_permit[i] is 1 exactly when bit 0 of register i is 0. Writing bit 0 to 1 blocks the block, and writing it to 0 unblocks it.
- R4: Once bit 1 of a register is 1, later writes to that register change nothing. Only reset clears it. The write that sets bit 1 also sets bit 0 from its own data.
- R5: While boot_prot_n is 0, wr_permit[NUM_BLOCKS-1] is 0 whatever that register holds. The other blocks are unaffected.
- R6: While main_prot_n is 0, wr_permit[i] is 0 for every i below NUM_BLOCKS-1 whatever the registers hold. The top block is unaffected.
- R7: The pin levels never appear in reg_rdata. The readback equals the stored register bits only.
- R8: When op_start is 1 at a clock edge, the following cycle shows op_grant_valid=1 and op_grant equal to the permission of op_block as it stood before that edge. op_grant holds until the next op_start.
- R9: While busy is 1, a write leaves the register unchanged, and a read produces no reg_rvalid and leaves reg_rdata unchanged.
- R10: Register indices at or above NUM_BLOCKS read as 8'h00, and writes to them have no effect.
- R11: A read accepted at an edge gives reg_rvalid=1 and reg_rdata in the next cycle. A read and a write to the same index in the same cycle return the value held before the write. When no read is accepted, reg_rdata holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | 8 | Write data |
| busy | input | 1 | Internal program/erase in progress |
| reg_rdata | output | 8 | Read data, held between reads |
| reg_rvalid | output | 1 | Read data valid, one cycle |
| boot_prot_n | input | 1 | Active-low protect for the top block |
| main_prot_n | input | 1 | Active-low protect for all other blocks |
| wr_permit | output | NUM_BLOCKS | Live per-block program/erase permission |
| op_start | input | 1 | Controller begins an operation |
| op_block | input | BLK_W | Block targeted by the operation |
| op_grant_valid | output | 1 | Sampled decision available |
| op_grant | output | 1 | Sampled permission for op_block |

## Verification
The assertions check several rules on every clock. A set lock-down flag freezes its register and never clears without reset. A lock-down flag cannot appear without an accepted write. A protect pin at 0 always forces the permit it covers to 0. Read data shows up only after a read that arrived while busy was 0, and never has reserved bits set. The bench scenarios are needed for the rest: that values written are really stored and read back, that the pins stay out of the readback, that the grant reflects the state before the starting edge and not after it, that indices out of range read as zero, and that reset clears lock-down.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int REG_W = 8;
  localparam int WL_BIT = 0;
  localparam int LD_BIT = 1;

  typedef struct packed {
    logic down;
    logic wlock;
  } lock_st_t;

  localparam lock_st_t LOCK_RST = '{down: 1'b0, wlock: 1'b1};

  function automatic logic [REG_W-1:0] pack_reg(input lock_st_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[WL_BIT] = s.wlock;
    v[LD_BIT] = s.down;
    return v;
  endfunction
endpackage

// File: rtl/lock_cell.sv
module lock_cell
  import lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wbits,
  output lock_st_t   st
);
  lock_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_en && !st_q.down) begin
      st_d.wlock = wbits[WL_BIT];
      st_d.down  = wbits[LD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LOCK_RST;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R4
  ld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.down |=> (st_q.down && $stable(st_q.wlock)));

  // R4
  ld_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.down) |-> $past(wr_en));
endmodule

// File: rtl/lock_prot_merge.sv
module lock_prot_merge #(
  parameter int NUM_BLOCKS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BLOCKS-1:0] wlock_vec,
  input  logic                  boot_prot_n,
  input  logic                  main_prot_n,
  output logic [NUM_BLOCKS-1:0] permit
);
  localparam int TOP = NUM_BLOCKS - 1;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    if (i == TOP) begin : g_boot
      assign permit[i] = !wlock_vec[i] && boot_prot_n;
    end else begin : g_main
      assign permit[i] = !wlock_vec[i] && main_prot_n;
    end
  end

  // R5
  boot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_prot_n |-> !permit[TOP]);

  // R6
  main_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_prot_n |-> (permit[TOP-1:0] == '0));
endmodule

// File: rtl/lock_rd_port.sv
module lock_rd_port
  import lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int ADDR_W = 5,
  parameter int BLK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req,
  input  logic                  busy,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BLOCKS-1:0] wlock_vec,
  input  logic [NUM_BLOCKS-1:0] down_vec,
  output logic [REG_W-1:0]      rdata,
  output logic                  rvalid
);
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             rvalid_q, rvalid_d;
  logic             in_range;
  logic             rd_en;
  logic [BLK_W-1:0] idx;
  lock_st_t         sel;

  assign rd_en    = rd_req && !busy;
  assign in_range = {1'b0, addr} < (ADDR_W+1)'(NUM_BLOCKS);
  assign idx      = addr[BLK_W-1:0];

  always_comb begin
    sel = LOCK_RST;
    sel.wlock = wlock_vec[idx];
    sel.down  = down_vec[idx];
  end

  always_comb begin
    rdata_d  = rdata_q;
    rvalid_d = 1'b0;
    if (rd_en) begin
      rvalid_d = 1'b1;
      rdata_d  = in_range ? pack_reg(sel) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R9
  rd_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |-> $past(rd_req && !busy));

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |-> (rdata_q[REG_W-1:2] == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/blk_lock_bank.sv
module blk_lock_bank
  import lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int ADDR_W = 5,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic                  busy,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  reg_rvalid,
  input  logic                  boot_prot_n,
  input  logic                  main_prot_n,
  output logic [NUM_BLOCKS-1:0] wr_permit,
  input  logic                  op_start,
  input  logic [BLK_W-1:0]      op_block,
  output logic                  op_grant_valid,
  output logic                  op_grant
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  logic irst_n;
  assign irst_n = rst_s2;

  logic [NUM_BLOCKS-1:0] wlock_vec, down_vec;
  logic                  wr_en;
  assign wr_en = reg_wr && !busy;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
    lock_st_t st;
    logic     hit;
    assign hit = wr_en && (reg_addr == ADDR_W'(i));
    lock_cell u_cell (
      .clk   (clk),
      .rst_n (irst_n),
      .wr_en (hit),
      .wbits (reg_wdata[1:0]),
      .st    (st)
    );
    assign wlock_vec[i] = st.wlock;
    assign down_vec[i]  = st.down;
  end

  lock_prot_merge #(.NUM_BLOCKS(NUM_BLOCKS)) u_merge (
    .clk         (clk),
    .rst_n       (irst_n),
    .wlock_vec   (wlock_vec),
    .boot_prot_n (boot_prot_n),
    .main_prot_n (main_prot_n),
    .permit      (wr_permit)
  );

  lock_rd_port #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_rd (
    .clk       (clk),
    .rst_n     (irst_n),
    .rd_req    (reg_rd),
    .busy      (busy),
    .addr      (reg_addr),
    .wlock_vec (wlock_vec),
    .down_vec  (down_vec),
    .rdata     (reg_rdata),
    .rvalid    (reg_rvalid)
  );

  // sampled decision for the program/erase controller
  logic gv_q, gv_d, g_q, g_d, blk_ok;
  assign blk_ok = ({1'b0, op_block} < (BLK_W+1)'(NUM_BLOCKS)) && wr_permit[op_block];

  always_comb begin
    gv_d = op_start;
    g_d  = g_q;
    if (op_start) g_d = blk_ok;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      gv_q <= 1'b0;
      g_q  <= 1'b0;
    end else begin
      gv_q <= gv_d;
      g_q  <= g_d;
    end
  end

  assign op_grant_valid = gv_q;
  assign op_grant       = g_q;

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!irst_n)
    !op_start |=> $stable(op_grant));

  // R8
  grant_pin_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (op_start && !boot_prot_n && op_block == BLK_W'(NUM_BLOCKS-1)) |=> !op_grant);
endmodule

// File: tb/tb_blk_lock_bank.sv
module tb_blk_lock_bank;
  localparam int NB = 16;
  localparam int AW = 5;
  localparam int BW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, reg_wr, reg_rd, busy, boot_prot_n, main_prot_n, op_start;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_rvalid, op_grant_valid, op_grant;
  logic [NB-1:0] wr_permit;
  logic [BW-1:0] op_block;

  blk_lock_bank #(.NUM_BLOCKS(NB), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .boot_prot_n(boot_prot_n), .main_prot_n(main_prot_n),
    .wr_permit(wr_permit), .op_start(op_start), .op_block(op_block),
    .op_grant_valid(op_grant_valid), .op_grant(op_grant)
  );

  int total = 0;
  int bad = 0;
  bit live = 0;

  // behavioural reference
  int m_wl[NB];
  int m_ld[NB];
  int m_rdata, m_rvalid, m_gv, m_g;

  function automatic int perm_of(int b);
    int pin;
    pin = (b == NB-1) ? int'(boot_prot_n) : int'(main_prot_n);
    return (m_wl[b] == 0 && pin == 1) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin m_wl[i] = 1; m_ld[i] = 0; end
      m_rdata = 0; m_rvalid = 0; m_gv = 0; m_g = 0;
    end else begin
      int a;
      a = int'(reg_addr);
      m_gv = int'(op_start);
      if (op_start) m_g = perm_of(int'(op_block));
      m_rvalid = 0;
      if (reg_rd && !busy) begin
        m_rvalid = 1;
        m_rdata = (a < NB) ? (m_ld[a] * 2 + m_wl[a]) : 0;
      end
      if (reg_wr && !busy && a < NB && m_ld[a] == 0) begin
        m_wl[a] = int'(reg_wdata[0]);
        m_ld[a] = int'(reg_wdata[1]);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R11 R9 reg_rvalid", int'(reg_rvalid), m_rvalid);
      chk("R1 R2 R4 R7 R10 R11 reg_rdata", int'(reg_rdata), m_rdata);
      for (int i = 0; i < NB; i++)
        chk("R3 R5 R6 wr_permit", int'(wr_permit[i]), perm_of(i));
      chk("R8 op_grant_valid", int'(op_grant_valid), m_gv);
      chk("R8 op_grant", int'(op_grant), m_g);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; op_start = 0;
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = 8'(d);
    tick(); idle();
  endtask

  task automatic rd(input int a);
    reg_rd = 1; reg_addr = AW'(a);
    tick(); idle();
    tick();
  endtask

  task automatic op(input int b);
    op_start = 1; op_block = BW'(b);
    tick(); idle();
    tick();
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; busy = 0; boot_prot_n = 1; main_prot_n = 1;
    reg_addr = '0; reg_wdata = '0; op_block = '0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    live = 1;
    // R2: reset values
    for (int i = 0; i < NB; i++) rd(i);
    // R3: unlock and relock
    wr(3, 8'h00); rd(3);
    wr(3, 8'h01); rd(3);
    wr(3, 8'h00);
    // R1: reserved bits discarded
    wr(4, 8'hFC); rd(4);
    // R4: locked open then frozen
    wr(5, 8'h02); wr(5, 8'h01); rd(5);
    wr(6, 8'h03); wr(6, 8'h00); rd(6);
    // R5 R7: boot pin
    wr(NB-1, 8'h00); boot_prot_n = 0; tick(); rd(NB-1);
    // R6 R7: main pin
    main_prot_n = 0; tick(); rd(3); main_prot_n = 1; tick();
    // R8: sample then change
    op(3); op(NB-1);
    boot_prot_n = 1; tick(); op(NB-1);
    op_start = 1; op_block = BW'(3); reg_wr = 1; reg_addr = 5'd3; reg_wdata = 8'h01;
    tick(); idle(); repeat (2) tick();
    // R9: busy drops accesses
    busy = 1; wr(7, 8'h00); rd(7); busy = 0; rd(7);
    // R10: out-of-range indices
    wr(20, 8'h00); rd(20); rd(NB);
    // R11: read and write together
    reg_rd = 1; reg_wr = 1; reg_addr = 5'd8; reg_wdata = 8'h00;
    tick(); idle(); rd(8);
    // R4 R2: reset clears lock-down
    rst_n = 0; tick(); tick(); rst_n = 1; repeat (4) tick();
    rd(6); rd(5); wr(6, 8'h00); rd(6);
    repeat (3) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule